// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block watches one external non-maskable interrupt wire, conditions it according to a programmable trigger type and keeps a sticky pending flag. The flag is gated by an enable bit and the result is registered onto a single request line that goes to a parent interrupt controller. The raw wire is asynchronous and passes through a two-flop synchronizer before any detection. The synchronizer and the previous-sample register reset to the inactive-high idle level.

Software reaches three registers through a plain single-cycle word bus. The bus has a byte address, a write strobe, write data, and read data that follows the address combinationally. The bus carries no stream and has no back-pressure: every write strobe is taken on the clock edge where it is high, and a read has no wait states.

A parameter selects one of two register maps. The two maps differ only in where the enable register sits.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the control, pending and enable registers all read 0 and `irq_out` is 0.
- R2: Control bits [1:0] select the trigger type: 0 = input low (level), 1 = high-to-low transition, 2 = input high (level), 3 = low-to-high transition.
- R3: The control register is at byte offset 0x00 and the pending register is at 0x04. The enable register is at 0x08 when `MAP_VARIANT`=0 and at 0x34 when `MAP_VARIANT`=1. The pending and enable registers read back their flag in bit 0, and all their other bits read 0.
- R4: Reads from any other offset return 0, and writes to any other offset change nothing. This includes the enable offset of the other map variant.
- R5: All 32 control bits are read/write storage. Rewriting the word with a new trigger field and the same upper bits leaves the upper bits unchanged on read-back.
- R6: A write with bit 0 = 1 to the pending offset clears the pending flag. A write with bit 0 = 0 leaves the flag unchanged.
- R7: In a level mode the flag is set again on every cycle the synchronized input is at its active level, so a clear issued while the level persists leaves the flag set.
- R8: When a detection event and a clear fall on the same clock edge, the flag ends up set.
- R9: On every clock `irq_out` takes the value of (pending AND enable bit 0) as it was before that edge. With the enable bit at 0, `irq_out` stays 0 whatever the pending flag is.
- R10: An input change reaches the detector after two synchronizer flops. The pending flag changes on the third rising clock edge after the input change, and `irq_out` changes on the fourth.
- R11: In an edge mode a single transition sets the flag once. After a clear, the flag stays clear while the input holds its new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Raw asynchronous interrupt wire |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Registered request to the parent controller |

## Verification
A software acknowledge of the pending flag can land on the same clock edge as a new detection event from the synchronized input. The bench provokes this in the edge mode by raising the input and then issuing the clear at each of several cycle offsets around the third edge, which is the edge where detection takes effect. It uses the same sweep with the level held active to cover the level case. A cycle-accurate behavioural model judges each outcome and expects the flag to remain set whenever the two coincide.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HIGH = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_PEND   = 'h04;
  localparam int unsigned OFS_EN_A   = 'h08;
  localparam int unsigned OFS_EN_B   = 'h34;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_trig_detect.sv
module nmi_trig_detect
  import nmi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lvl,
  input  trig_e trig,
  output logic  evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  always_comb begin
    unique case (trig)
      TRIG_LVL_LOW:   evt = ~lvl;
      TRIG_EDGE_FALL: evt = prev_q & ~lvl;
      TRIG_LVL_HIGH:  evt = lvl;
      TRIG_EDGE_RISE: evt = ~prev_q & lvl;
      default:        evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/nmi_regfile.sv
module nmi_regfile
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_OFS = OFS_EN_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt,
  output logic              pend_q,
  output logic              en_q,
  output trig_e             trig
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

  logic [DATA_W-1:0] ctrl_q;
  logic              hit_ctrl, hit_pend, hit_en;
  logic              ack;

  assign hit_ctrl = (bus_addr == A_CTRL);
  assign hit_pend = (bus_addr == A_PEND);
  assign hit_en   = (bus_addr == A_EN);
  assign ack      = bus_we & hit_pend & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else if (bus_we) begin
      if (hit_ctrl) ctrl_q <= bus_wdata;
      if (hit_en)   en_q   <= bus_wdata[0];
    end
  end

  // detection has priority over acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (evt) pend_q <= 1'b1;
    else if (ack) pend_q <= 1'b0;
  end

  assign trig = trig_e'(ctrl_q[1:0]);

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = ctrl_q;
    else if (hit_pend) bus_rdata[0] = pend_q;
    else if (hit_en)   bus_rdata[0] = en_q;
  end
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter bit          MAP_VARIANT = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int unsigned EN_OFS = MAP_VARIANT ? OFS_EN_B : OFS_EN_A;

  logic  sync_lvl;
  logic  evt;
  logic  pend_q;
  logic  en_q;
  trig_e trig;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(nmi_in), .dout(sync_lvl)
  );

  nmi_trig_detect u_det (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .trig(trig), .evt(evt)
  );

  nmi_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFS(EN_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .evt(evt), .pend_q(pend_q), .en_q(en_q), .trig(trig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_q & en_q;
  end
endmodule

// File: rtl/nmi_line_ctrl_chk.sv
module nmi_line_ctrl_chk
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_OFS = OFS_EN_A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic              evt,
  input logic              pend_q,
  input logic              en_q
);
  logic wr_pend, mapped;
  assign wr_pend = bus_we && (bus_addr == ADDR_W'(OFS_PEND));
  assign mapped  = (bus_addr == ADDR_W'(OFS_CTRL)) || (bus_addr == ADDR_W'(OFS_PEND)) ||
                   (bus_addr == ADDR_W'(EN_OFS));

  assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && en_q) |=> irq_out);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && en_q) |=> !irq_out);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && bus_wdata[0] && !evt) |=> !pend_q);

  assert_zero_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !bus_wdata[0] && pend_q) |=> pend_q);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend_q);

  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0));
endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFS(EN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .evt(evt), .pend_q(pend_q), .en_q(en_q)
);

// File: tb/sim_nmi_line_ctrl.sv
module sim_nmi_line_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_in = 1'b1;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  nmi_line_ctrl #(.MAP_VARIANT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rd0), .irq_out(irq0));

  nmi_line_ctrl #(.MAP_VARIANT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rd1), .irq_out(irq1));

  // behavioural reference, advanced on every rising edge
  logic        m_s1, m_s2, m_prv, m_pend, m_en0, m_en1, m_q0, m_q1, m_ev;
  logic [31:0] m_ctrl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prv = 1; m_pend = 0; m_en0 = 0; m_en1 = 0;
      m_q0 = 0; m_q1 = 0; m_ctrl = 0;
    end else begin
      case (m_ctrl[1:0])
        2'd0: m_ev = !m_s2;
        2'd1: m_ev = m_prv && !m_s2;
        2'd2: m_ev = m_s2;
        default: m_ev = !m_prv && m_s2;
      endcase
      m_q0 = m_pend & m_en0;
      m_q1 = m_pend & m_en1;
      if (m_ev) m_pend = 1;
      else if (we && addr == 8'h04 && wdata[0]) m_pend = 0;
      if (we && addr == 8'h00) m_ctrl = wdata;
      if (we && addr == 8'h08) m_en0 = wdata[0];
      if (we && addr == 8'h34) m_en1 = wdata[0];
      m_prv = m_s2; m_s2 = m_s1; m_s1 = nmi_in;
    end
  end

  function automatic logic [31:0] exp_rd(bit variant, logic [7:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h04) return {31'b0, m_pend};
    if (!variant && a == 8'h08) return {31'b0, m_en0};
    if (variant && a == 8'h34) return {31'b0, m_en1};
    return 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk({31'b0, irq0}, {31'b0, m_q0}, "irq_out u0");
      chk({31'b0, irq1}, {31'b0, m_q1}, "irq_out u1");
      chk(rd0, exp_rd(1'b0, addr), "rdata u0");
      chk(rd1, exp_rd(1'b1, addr), "rdata u1");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); addr = a;
    @(negedge clk);
  endtask

  task automatic drive(input logic v);
    @(negedge clk); nmi_in = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    cur_req = "R1";
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h34);

    cur_req = "R3";
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08); rd(8'h34);
    wr(8'h34, 32'h0000_0001); rd(8'h34); rd(8'h08);

    cur_req = "R4";
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10); rd(8'h3C); rd(8'h00); rd(8'h04);

    cur_req = "R5";
    wr(8'h00, 32'hC3A5_5A00); rd(8'h00);
    wr(8'h00, 32'hC3A5_5A03); rd(8'h00);
    wr(8'h00, 32'hC3A5_5A01); rd(8'h00);

    // R2 / R10 / R11: each trigger type, rising-edge mode first
    cur_req = "R10";
    wr(8'h00, 32'h3); addr = 8'h04;
    drive(1'b0); tick(4); drive(1'b1);
    tick(6);
    cur_req = "R11";
    wr(8'h04, 32'h1); rd(8'h04); tick(4);
    drive(1'b0); tick(5);

    cur_req = "R2";
    for (int m = 0; m < 4; m++) begin
      wr(8'h00, 32'hF0F0_0000 | m);
      drive(1'b1); tick(4);
      wr(8'h04, 32'h1); addr = 8'h04; tick(2);
      drive(1'b0); tick(5);
      wr(8'h04, 32'h1); addr = 8'h04; tick(2);
      drive(1'b1); tick(5);
      wr(8'h04, 32'h1); addr = 8'h04; tick(3);
    end

    cur_req = "R7";
    wr(8'h00, 32'h2); drive(1'b1); tick(4);
    wr(8'h04, 32'h1); addr = 8'h04; tick(2);
    wr(8'h04, 32'h1); tick(2);
    drive(1'b0); tick(4);
    wr(8'h04, 32'h1); addr = 8'h04; tick(3);

    cur_req = "R8";
    for (int lvl_mode = 0; lvl_mode < 2; lvl_mode++) begin
      wr(8'h00, lvl_mode ? 32'h2 : 32'h3);
      for (int k = 0; k < 6; k++) begin
        drive(1'b0); tick(4);
        wr(8'h04, 32'h1);
        @(negedge clk); nmi_in = 1'b1;
        repeat (k) @(negedge clk);
        addr = 8'h04; wdata = 32'h1; we = 1'b1;
        @(negedge clk); we = 1'b0;
        tick(4);
      end
      drive(1'b0); tick(4);
    end

    cur_req = "R6";
    wr(8'h00, 32'h3); drive(1'b0); tick(3); drive(1'b1); tick(5);
    wr(8'h04, 32'hFFFF_FFFE); rd(8'h04); tick(2);
    wr(8'h04, 32'h1); rd(8'h04);

    cur_req = "R9";
    wr(8'h08, 32'h0); wr(8'h34, 32'h0);
    drive(1'b0); tick(3); drive(1'b1); tick(6);
    wr(8'h08, 32'h1); tick(3);
    wr(8'h34, 32'h1); tick(3);
    wr(8'h08, 32'h0); tick(3);
    wr(8'h04, 32'h1); tick(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule